// File: doc/BRIEF.md
# Edge/Center-Aligned PWM Timer

This block produces one pulse-width-modulated output from a free-running counter. Software first sets a prescale factor, a period and a compare value through a small write port. It then enables the timer, and after that the timer runs without further attention. The counter has two shapes. In edge-aligned mode it is a sawtooth: it counts up to the period and restarts at zero. In center-aligned mode it is a triangle: it climbs to the period and then falls back to zero. In center-aligned mode the block also emits a single-clock trigger at the peak of the triangle. That instant is the middle of both the period and the high pulse, which makes it a quiet point for sampling phase current with an ADC.

The prescaler is a clock-enable divider: each counter value lasts N+1 clocks. Period, compare, prescale and mode writes go into shadow copies. The running copies take them only at the update event, so a cycle never mixes old and new settings. The update event is the wrap to zero in edge mode and the return to zero in center mode. While the timer is stopped, the running copies follow the shadows at once.

A counter state machine has three states:
- OFF: stopped, count held at 0. Its only exit is OFF→UP, taken when enabled.
- UP: counting upward. Its transitions are:
  - UP→UP on a wrap or an ordinary step;
  - UP→DOWN at the peak in center mode;
  - any state→OFF on disable.
- DOWN: counting downward. Its transitions are:
  - DOWN→DOWN while stepping;
  - DOWN→UP on reaching zero.

Top module: `pwm_timer`

## Requirements
- R1: After reset the timer is stopped: pwm_out and adc_trig are low, and every setting reads as zero (prescale 0, period 0, compare 0, edge mode, disabled).
- R2: In edge mode (control bit 1 = 0) the count runs 0,1,…,P and then restarts at 0. pwm_out is high exactly while count < C, so it is high C of every P+1 count steps.
- R3: The prescale register (address 1) holds N. Every count value lasts N+1 clocks. The edge period is therefore (P+1)(N+1) clocks, and the center period is 2P(N+1) clocks.
- R4: In center mode (control bit 1 = 1) the count runs 0,1,…,P,P−1,…,1 and repeats. pwm_out is high while count + C > P, which places the pulse symmetrically about the peak count P.
- R5: In center mode with P ≥ 1, adc_trig is high for exactly one clock: the first clock in which the count equals P. In edge mode adc_trig never goes high.
- R6: Writes to the period (address 2), the compare (address 3), the prescale (address 1) and the mode bit reach the running timer only at the update event: the edge-mode wrap to 0, or the center-mode arrival at 0. While the timer is disabled, a write takes effect on the next clock.
- R7: C = 0 keeps pwm_out low for whole periods, and C > P keeps it high for whole periods, in both modes.
- R8: P = 0 holds the count at 0, keeps pwm_out low and keeps adc_trig low. A later nonzero period is picked up at the next prescaled step.
- R9: Control register address 0, bit 0 is the enable. It acts on the next clock. Clearing it forces pwm_out low, returns the count to 0 and restarts the prescaler. Setting it starts counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 prescale, 2 period, 3 compare |
| wr_data | input | CNT_W | Write data (control uses bit 0 enable, bit 1 center mode) |
| pwm_out | output | 1 | PWM output |
| adc_trig | output | 1 | One-clock trigger at the center-mode peak |

## Verification
A wrong count or direction changes the run of high clocks on pwm_out within one period. In center mode it also moves or duplicates the adc_trig pulse, which shows at the next peak. A shadow copy that loads at the wrong moment changes the duty or period partway through a cycle instead of at the update event. Comparing against a reference model on every clock catches such errors at the first clock where the two diverge, not at the end of a period. Measured counts over whole periods also confirm the duty and trigger rates.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } pwm_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PSC  = 2'd1;
    localparam logic [1:0] ADDR_PER  = 2'd2;
    localparam logic [1:0] ADDR_CMP  = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CEN_BIT = 1;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic             en_q,
    output logic             mode_a,
    output logic [PSC_W-1:0] psc_a,
    output logic [CNT_W-1:0] per_a,
    output logic [CNT_W-1:0] cmp_a
);

    logic             mode_s;
    logic [PSC_W-1:0] psc_s;
    logic [CNT_W-1:0] per_s;
    logic [CNT_W-1:0] cmp_s;

    // Shadow copies written by software; enable acts immediately
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_s <= 1'b0;
            psc_s  <= '0;
            per_s  <= '0;
            cmp_s  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    en_q   <= wr_data[CTRL_EN_BIT];
                    mode_s <= wr_data[CTRL_CEN_BIT];
                end
                ADDR_PSC: psc_s <= wr_data[PSC_W-1:0];
                ADDR_PER: per_s <= wr_data;
                ADDR_CMP: cmp_s <= wr_data;
                default: ;
            endcase
        end
    end

    // Running copies taken from the shadows at the update event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_a <= 1'b0;
            psc_a  <= '0;
            per_a  <= '0;
            cmp_a  <= '0;
        end else if (load) begin
            mode_a <= mode_s;
            psc_a  <= psc_s;
            per_a  <= per_s;
            cmp_a  <= cmp_s;
        end
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc_a,
    output logic             tick
);

    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

    logic [PSC_W-1:0] div_q;

    assign tick = run && (div_q == psc_a);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PSC_ONE;
        end
    end

endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] per,
    output pwm_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             load,
    output logic             adc_trig
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W:0]   WIDE_ONE = (CNT_W+1)'(1);

    pwm_state_e       state_n;
    logic [CNT_W-1:0] cnt_n;
    logic             upd;
    logic             trig_n;
    logic             at_peak_next;

    assign at_peak_next = (({1'b0, cnt_q} + WIDE_ONE) == {1'b0, per});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            cnt_q    <= '0;
            adc_trig <= 1'b0;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            adc_trig <= trig_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        upd     = 1'b0;
        trig_n  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_n = '0;
                if (en) begin
                    state_n = ST_UP;
                end
            end
            ST_UP: begin
                if (tick) begin
                    if (cnt_q >= per) begin
                        if (center && (per > CNT_ONE)) begin
                            state_n = ST_DOWN;
                            cnt_n   = cnt_q - CNT_ONE;
                        end else begin
                            cnt_n = '0;
                            upd   = 1'b1;
                        end
                    end else begin
                        cnt_n  = cnt_q + CNT_ONE;
                        trig_n = center && at_peak_next;
                    end
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    cnt_n = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        state_n = ST_UP;
                        upd     = 1'b1;
                    end
                end
            end
            default: begin
                state_n = ST_OFF;
                cnt_n   = '0;
            end
        endcase
        if (!en) begin
            state_n = ST_OFF;
            cnt_n   = '0;
            upd     = 1'b0;
            trig_n  = 1'b0;
        end
    end

    assign load = upd || (state_q == ST_OFF);

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             center,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm_out
);

    logic [CNT_W:0] sum_w;
    logic           hi_edge;
    logic           hi_center;

    assign sum_w     = {1'b0, cnt} + {1'b0, cmp};
    assign hi_edge   = (cnt < cmp);
    assign hi_center = (cmp > per) || (sum_w > {1'b0, per});

    always_comb begin
        if (!run || (per == '0)) begin
            pwm_out = 1'b0;
        end else if (center) begin
            pwm_out = hi_center;
        end else begin
            pwm_out = hi_edge;
        end
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             adc_trig
);

    logic             en_q;
    logic             mode_a;
    logic [PSC_W-1:0] psc_a;
    logic [CNT_W-1:0] per_a;
    logic [CNT_W-1:0] cmp_a;
    logic             load;
    logic             tick;
    logic             run;
    pwm_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign run = (state_q != ST_OFF);

    pwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .en_q    (en_q),
        .mode_a  (mode_a),
        .psc_a   (psc_a),
        .per_a   (per_a),
        .cmp_a   (cmp_a)
    );

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psc_a (psc_a),
        .tick  (tick)
    );

    pwm_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .tick     (tick),
        .center   (mode_a),
        .per      (per_a),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .load     (load),
        .adc_trig (adc_trig)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .run     (run),
        .center  (mode_a),
        .cnt     (cnt_q),
        .per     (per_a),
        .cmp     (cmp_a),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             tick,
    input logic             load,
    input pwm_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_a,
    input logic [CNT_W-1:0] cmp_a,
    input logic             mode_a,
    input logic             pwm_out,
    input logic             adc_trig
);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_a);

    assert_prescale_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && en_q && state_q != ST_OFF) |=> $stable(cnt_q));

    assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    assert_trig_at_peak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (mode_a && cnt_q == per_a));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(per_a) && $stable(cmp_a) && $stable(mode_a)));

    assert_cmp_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a == '0) |-> !pwm_out);

    assert_zero_period_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_a == '0) |-> (!pwm_out && !adc_trig));

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!pwm_out && !adc_trig && cnt_q == '0));

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .tick     (tick),
    .load     (load),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .per_a    (per_a),
    .cmp_a    (cmp_a),
    .mode_a   (mode_a),
    .pwm_out  (pwm_out),
    .adc_trig (adc_trig)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_out;
    logic             adc_trig;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    pwm_timer #(.CNT_W(CNT_W), .PSC_W(CNT_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out),
        .adc_trig (adc_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_en, m_run, m_dn, m_cnt, m_pc, m_trig;
    int s_cen, s_psc, s_per, s_cmp;
    int a_cen, a_psc, a_per, a_cmp;

    initial begin
        m_en = 0; m_run = 0; m_dn = 0; m_cnt = 0; m_pc = 0; m_trig = 0;
        s_cen = 0; s_psc = 0; s_per = 0; s_cmp = 0;
        a_cen = 0; a_psc = 0; a_per = 0; a_cmp = 0;
    end

    function automatic int model_pwm();
        if (m_run == 0 || a_per == 0) return 0;
        if (a_cen != 0) return ((a_cmp > a_per) || (m_cnt + a_cmp > a_per)) ? 1 : 0;
        return (m_cnt < a_cmp) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int ld;
        int tg;
        if (!rst_n) begin
            m_en = 0; m_run = 0; m_dn = 0; m_cnt = 0; m_pc = 0; m_trig = 0;
            s_cen = 0; s_psc = 0; s_per = 0; s_cmp = 0;
            a_cen = 0; a_psc = 0; a_per = 0; a_cmp = 0;
        end else begin
            ld = 0;
            tg = 0;
            if (m_en == 0) begin
                m_run = 0; m_cnt = 0; m_pc = 0; m_dn = 0; ld = 1;
            end else if (m_run == 0) begin
                m_run = 1; m_cnt = 0; m_pc = 0; m_dn = 0; ld = 1;
            end else if (m_pc == a_psc) begin
                m_pc = 0;
                if (m_dn == 0) begin
                    if (m_cnt >= a_per) begin
                        if (a_cen != 0 && a_per > 1) begin
                            m_dn = 1; m_cnt = m_cnt - 1;
                        end else begin
                            m_cnt = 0; ld = 1;
                        end
                    end else begin
                        m_cnt = m_cnt + 1;
                        if (a_cen != 0 && m_cnt == a_per) tg = 1;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        m_dn = 0; ld = 1;
                    end
                end
            end else begin
                m_pc = m_pc + 1;
            end
            if (ld != 0) begin
                a_cen = s_cen; a_psc = s_psc; a_per = s_per; a_cmp = s_cmp;
            end
            m_trig = tg;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_en = int'(wr_data[0]); s_cen = int'(wr_data[1]); end
                    2'd1: s_psc = int'(wr_data);
                    2'd2: s_per = int'(wr_data);
                    default: s_cmp = int'(wr_data);
                endcase
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (int'(pwm_out) != model_pwm() || int'(adc_trig) != m_trig) begin
                n_bad++;
                $display("FAIL %s: pwm_out/adc_trig actual %0d/%0d expected %0d/%0d at %0t",
                         cur_req, pwm_out, adc_trig, model_pwm(), m_trig, $time);
            end
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hi, output int tr);
        hi = 0;
        tr = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            hi += int'(pwm_out);
            tr += int'(adc_trig);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hi, tr;
        idle(4);
        // R1: reset state
        check("R1 pwm_out in reset", int'(pwm_out), 0);
        check("R1 adc_trig in reset", int'(adc_trig), 0);
        rst_n = 1'b1;
        measure(6, hi, tr);
        check("R1 pwm_out idle after reset", hi, 0);

        // R2: edge mode P=9 C=4 N=0, period 10 clocks, 4 high
        cur_req = "R2";
        wr(1, 0); wr(2, 9); wr(3, 4); wr(0, 1);
        idle(30);
        measure(30, hi, tr);
        check("R2 edge high clocks", hi, 12);
        check("R5 no trigger in edge mode", tr, 0);

        // R3: prescale N=2, period 30 clocks, 12 high
        cur_req = "R3";
        wr(1, 2);
        idle(90);
        measure(60, hi, tr);
        check("R3 prescaled high clocks", hi, 24);

        // R4: center mode P=8 C=3, period 16 clocks, 5 high, one trigger
        cur_req = "R4";
        wr(1, 0); wr(2, 8); wr(3, 3); wr(0, 3);
        idle(60);
        measure(32, hi, tr);
        check("R4 center high clocks", hi, 10);
        check("R5 center triggers per two periods", tr, 2);

        // R7: compare extremes in center and edge modes
        cur_req = "R7";
        wr(3, 0);
        idle(40);
        measure(32, hi, tr);
        check("R7 center C=0 low", hi, 0);
        wr(3, 20);
        idle(40);
        measure(32, hi, tr);
        check("R7 center C>P high", hi, 32);
        wr(0, 1);
        idle(40);
        measure(27, hi, tr);
        check("R7 edge C>P high", hi, 27);
        wr(3, 0);
        idle(30);
        measure(27, hi, tr);
        check("R7 edge C=0 low", hi, 0);

        // R8: zero period in both modes, then recovery
        cur_req = "R8";
        wr(3, 4); wr(2, 0);
        idle(20);
        measure(20, hi, tr);
        check("R8 edge P=0 low", hi, 0);
        wr(0, 3);
        idle(10);
        measure(20, hi, tr);
        check("R8 center P=0 low", hi, 0);
        check("R8 center P=0 no trigger", tr, 0);
        wr(2, 5); wr(3, 2);
        idle(30);
        measure(20, hi, tr);
        check("R8 recovered center high clocks", hi, 6);
        check("R8 recovered center triggers", tr, 2);

        // R6: shadow writes mid-period, compared clock by clock
        cur_req = "R6";
        wr(0, 1); wr(2, 49); wr(3, 10);
        idle(120);
        wr(3, 40);
        idle(7);
        wr(2, 19);
        idle(13);
        wr(0, 3);
        idle(150);
        measure(40, hi, tr);
        check("R6 center P=19 C=40 high", hi, 40);
        check("R6 center P=19 triggers", tr, 1);

        // R9: disable forces low and restarts from 0
        cur_req = "R9";
        wr(0, 2);
        idle(1);
        measure(30, hi, tr);
        check("R9 disabled pwm low", hi, 0);
        check("R9 disabled no trigger", tr, 0);
        wr(2, 9); wr(3, 4); wr(0, 1);
        measure(10, hi, tr);
        check("R9 first edge period after enable", hi, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule